// File: doc/BRIEF.md
# Single-Cycle MIPS Subset Processor

This block is a small 32-bit integer processor. It fetches one instruction and completes it in each clock cycle. It has no pipeline, so it needs no stall, forwarding or hazard logic. It decodes a narrow MIPS-I subset:

- immediate forms: upper-immediate load, OR with immediate, add immediate unsigned;
- register forms: add unsigned, NOR;
- memory forms: word load, word store;
- control flow: absolute jump, jump-and-link, jump through a register;
- the all-zero no-op.

Any encoding outside this set leaves all state unchanged.

The core keeps the branch delay slot of the architecture. A second program-counter register always holds the address of the instruction that runs next. A jump therefore takes effect one instruction late. The instruction after the jump executes first, and only then does control reach the target.

Instruction fetch and data access use separate read-data inputs. This lets both complete in the same cycle. No address translation is done: the address the core computes is the address it drives on the bus. Leaving reset, the first fetch is from a fixed byte address set by a parameter.

Top module: `mips_lite_core`

## Requirements
- R1: In the first cycle after reset is released, the fetch address equals RESET_PC (default 0x0000_0010).
- R2: Each clock cycle completes exactly one instruction. Without a control transfer, the fetch address advances by 4 per cycle.
- R3: After a jump (opcode 2), a jump-and-link (opcode 3) or a register jump (opcode 0 with function 8), the next fetch is the sequential delay-slot instruction. The target is fetched in the cycle after that.
- R4: A jump-and-link writes the address of the jump plus 8 into register 31.
- R5: A jump or jump-and-link target is built from three parts, high to low:
  - bits 31:28 of the delay-slot address;
  - the 26-bit index in instruction bits 25:0;
  - two zero bits.
- R6: A word store (opcode 0x2B) drives all of the following in its own cycle:
  - write strobe high and address strobe high;
  - byte enables 4'b1111;
  - address equal to base register plus the sign-extended 16-bit offset;
  - write data equal to the full 32-bit value of the register in bits 20:16.
- R7: A word load (opcode 0x23) drives the read strobe, the address strobe and byte enables 4'b1111, at the same address formed as for a store. It writes the data-read input into the register named by bits 20:16.
- R8: Register 0 reads as zero, and writes to it are discarded.
- R9: The three immediate forms treat the 16-bit immediate differently:
  - upper-immediate load (opcode 0x0F) puts the immediate in bits 31:16 and zeros bits 15:0;
  - OR-immediate (opcode 0x0D) zero-extends the immediate;
  - add-immediate (opcode 0x09) sign-extends it.
- R10: Two register-to-register forms write the register named by bits 15:11:
  - opcode 0 with function 0x21 writes the 32-bit sum of the two source registers;
  - opcode 0 with function 0x27 writes the bitwise NOR of the two source registers.
- R11: Whenever the instruction is neither a load nor a store, the read strobe, the write strobe and the address strobe are all low, and the byte enables are 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | output | 32 | Byte address of the instruction executing this cycle |
| fetch_data | input | 32 | Instruction word read at fetch_addr |
| bus_addr | output | 32 | Data access byte address (physical equals virtual) |
| bus_wdata | output | 32 | Store data |
| bus_rdata | input | 32 | Load data returned for bus_addr |
| bus_rd | output | 1 | Read strobe for a load |
| bus_wr | output | 1 | Write strobe for a store |
| bus_ale | output | 1 | Address-latch strobe, high when an access is present |
| bus_be | output | 4 | Byte enables qualifying the access |

## Verification
The bench builds the core with the default start address of 0x10. This places the program at the low end of the address space, where a jump index of a few words reaches the subroutine.

That program is short, and each instruction in it covers a different requirement:
- the upper-immediate load and OR-immediate pair produce 0xCAFEBABE, a value with the immediate's sign bit set, so a sign-extending OR would show up;
- a NOR of two zero registers yields all ones;
- a jump-and-link and a register return both run their delay slots, and the subroutine stores the link value;
- a load-then-add chain follows;
- a write aimed at register 0 is followed by a store of that register;
- the program ends in a self-jump loop.

A scoreboard compares every fetch address in order against the expected control flow, and every store against the expected address, data and byte enables.

// File: rtl/mips_lite_core.sv
module mips_lite_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] fetch_addr,
  input  logic [31:0] fetch_data,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic        bus_ale,
  output logic [3:0]  bus_be
);
  localparam logic [5:0] OP_SPECIAL = 6'h00, OP_J = 6'h02, OP_JAL = 6'h03,
                         OP_ADDIU = 6'h09, OP_ORI = 6'h0D, OP_LUI = 6'h0F,
                         OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [5:0] FN_JR = 6'h08, FN_ADDU = 6'h21, FN_NOR = 6'h27;
  localparam logic [4:0] LINK_REG = 5'd31;

  logic [31:0] pc, npc, nxt;
  logic [31:0] gpr [32];

  wire [5:0]  op   = fetch_data[31:26];
  wire [5:0]  fn   = fetch_data[5:0];
  wire [4:0]  ra   = fetch_data[25:21];
  wire [4:0]  rb   = fetch_data[20:16];
  wire [4:0]  rc   = fetch_data[15:11];
  wire        shz  = (fetch_data[10:6] == 5'd0);
  wire [31:0] va   = gpr[ra];
  wire [31:0] vb   = gpr[rb];
  wire [31:0] simm = {{16{fetch_data[15]}}, fetch_data[15:0]};
  wire [31:0] zimm = {16'h0, fetch_data[15:0]};

  logic        wen;
  logic [4:0]  wsel;
  logic [31:0] wval;

  assign fetch_addr = pc;
  assign bus_rd     = (op == OP_LW);
  assign bus_wr     = (op == OP_SW);
  assign bus_ale    = bus_rd | bus_wr;
  assign bus_be     = {4{bus_ale}};
  assign bus_addr   = bus_ale ? va + simm : 32'h0;
  assign bus_wdata  = bus_wr ? vb : 32'h0;

  always_comb begin
    wen  = 1'b0;
    wsel = rb;
    wval = 32'h0;
    nxt  = npc + 32'd4;
    case (op)
      OP_LUI:   begin wen = 1'b1; wval = {fetch_data[15:0], 16'h0}; end
      OP_ORI:   begin wen = 1'b1; wval = va | zimm; end
      OP_ADDIU: begin wen = 1'b1; wval = va + simm; end
      OP_LW:    begin wen = 1'b1; wval = bus_rdata; end
      OP_J:     nxt = {npc[31:28], fetch_data[25:0], 2'b00};
      OP_JAL: begin
        nxt  = {npc[31:28], fetch_data[25:0], 2'b00};
        wen  = 1'b1;
        wsel = LINK_REG;
        wval = npc + 32'd4;
      end
      OP_SPECIAL: if (shz) begin
        case (fn)
          FN_ADDU: begin wen = 1'b1; wsel = rc; wval = va + vb; end
          FN_NOR:  begin wen = 1'b1; wsel = rc; wval = ~(va | vb); end
          FN_JR:   nxt = va;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      npc <= RESET_PC + 32'd4;
      for (int i = 0; i < 32; i++) gpr[i] <= 32'h0;
    end else begin
      pc  <= npc;
      npc <= nxt;
      if (wen && wsel != 5'd0) gpr[wsel] <= wval;
    end
  end
endmodule

module mips_lite_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0010
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fetch_addr,
  input logic [31:0] fetch_data,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_ale,
  input logic [3:0]  bus_be
);
  wire is_jimm = (fetch_data[31:26] == 6'h02) || (fetch_data[31:26] == 6'h03);
  wire is_jreg = (fetch_data[31:26] == 6'h00) && (fetch_data[5:0] == 6'h08)
                 && (fetch_data[10:6] == 5'd0);
  wire is_xfer = is_jimm || is_jreg;

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> fetch_addr == RESET_PC);

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && !$past(is_xfer, 2)) |->
      fetch_addr == $past(fetch_addr) + 32'd4);

  assert_delay_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_xfer)) |-> fetch_addr == $past(fetch_addr) + 32'd4);

  assert_store_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_ale && bus_be == 4'hF && !bus_rd));

  assert_load_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_ale && bus_be == 4'hF && !bus_wr));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (!bus_ale && bus_be == 4'h0));
endmodule

bind mips_lite_core mips_lite_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ale(bus_ale), .bus_be(bus_be)
);

// File: tb/mips_lite_core_tb.sv
module mips_lite_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr, fetch_data, bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_ale;
  logic [3:0]  bus_be;
  logic [31:0] dm [64];
  logic [31:0] exp_fetch [$];
  logic [31:0] exp_waddr [$];
  logic [31:0] exp_wdata [$];
  string       exp_wtag  [$];
  int          n_run = 0, n_fail = 0;
  bit          running = 1'b0;

  always #4 clk = ~clk;

  mips_lite_core u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ale(bus_ale), .bus_be(bus_be)
  );

  always_comb begin
    case (fetch_addr)
      32'h10: fetch_data = 32'h3c01cafe; // LUI r1,0xCAFE
      32'h14: fetch_data = 32'h3421babe; // ORI r1,r1,0xBABE
      32'h18: fetch_data = 32'h24050400; // ADDIU r5,r0,0x400
      32'h1C: fetch_data = 32'haca10000; // SW r1,0(r5)
      32'h20: fetch_data = 32'h00001027; // NOR r2,r0,r0
      32'h24: fetch_data = 32'haca20004; // SW r2,4(r5)
      32'h28: fetch_data = 32'h0c000020; // JAL 0x80
      32'h2C: fetch_data = 32'h24030007; // ADDIU r3,r0,7 (delay slot)
      32'h30: fetch_data = 32'haca30008; // SW r3,8(r5)
      32'h34: fetch_data = 32'h8ca40008; // LW r4,8(r5)
      32'h38: fetch_data = 32'h00833021; // ADDU r6,r4,r3
      32'h3C: fetch_data = 32'haca6000c; // SW r6,12(r5)
      32'h40: fetch_data = 32'h24000005; // ADDIU r0,r0,5
      32'h44: fetch_data = 32'haca00010; // SW r0,16(r5)
      32'h48: fetch_data = 32'haca70018; // SW r7,24(r5)
      32'h4C: fetch_data = 32'h08000013; // J 0x4C
      32'h80: fetch_data = 32'hacbf0014; // SW r31,20(r5)
      32'h84: fetch_data = 32'h03e00008; // JR r31
      32'h88: fetch_data = 32'h2407ffff; // ADDIU r7,r0,-1 (delay slot)
      default: fetch_data = 32'h0;       // NOP
    endcase
  end

  assign bus_rdata = dm[bus_addr[7:2]];
  always @(posedge clk) if (bus_wr) dm[bus_addr[7:2]] <= bus_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [31:0] a, input logic [31:0] d,
                              input string tag);
    exp_waddr.push_back(a);
    exp_wdata.push_back(d);
    exp_wtag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (exp_fetch.size() > 0) begin
        logic [31:0] f;
        f = exp_fetch.pop_front();
        check(fetch_addr == f, "R2/R3/R5 fetch order", fetch_addr, f);
      end
      if (bus_wr) begin
        if (exp_waddr.size() == 0) begin
          check(1'b0, "R6 unexpected store", bus_addr, 32'h0);
        end else begin
          logic [31:0] a, d;
          string t;
          a = exp_waddr.pop_front();
          d = exp_wdata.pop_front();
          t = exp_wtag.pop_front();
          check(bus_addr == a, {t, " addr"}, bus_addr, a);
          check(bus_wdata == d, {t, " data"}, bus_wdata, d);
          check(bus_be == 4'hF && bus_ale, "R6 be/ale", {28'h0, bus_be}, 32'hF);
        end
      end
      if (bus_rd) begin
        check(bus_addr == 32'h408 && bus_be == 4'hF && bus_ale,
              "R7 load access", bus_addr, 32'h408);
      end
      if (fetch_data == 32'h0 || fetch_data[31:26] == 6'h02) begin
        check(!bus_rd && !bus_wr && !bus_ale && bus_be == 4'h0,
              "R11 idle bus", {28'h0, bus_be}, 32'h0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) dm[i] = 32'h0;
    foreach (exp_fetch[i]) exp_fetch.delete();
    exp_fetch = '{32'h10, 32'h14, 32'h18, 32'h1C, 32'h20, 32'h24, 32'h28,
                  32'h2C, 32'h80, 32'h84, 32'h88, 32'h30, 32'h34, 32'h38,
                  32'h3C, 32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h4C,
                  32'h50, 32'h4C};
    expect_write(32'h400, 32'hCAFEBABE, "R9 LUI/ORI zero-extend");
    expect_write(32'h404, 32'hFFFFFFFF, "R10 NOR");
    expect_write(32'h414, 32'h00000030, "R4 link value");
    expect_write(32'h408, 32'h00000007, "R3 delay slot executed");
    expect_write(32'h40C, 32'h0000000E, "R7/R10 load then ADDU");
    expect_write(32'h410, 32'h00000000, "R8 r0 stays zero");
    expect_write(32'h418, 32'hFFFFFFFF, "R9 ADDIU sign-extend");
    repeat (3) @(posedge clk);
    #2;
    check(fetch_addr == 32'h10, "R1 reset fetch", fetch_addr, 32'h10);
    check(!bus_wr, "R1 no store in reset", {31'h0, bus_wr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    fork
      begin
        while (exp_fetch.size() > 0 || exp_waddr.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (2000) @(posedge clk);
        check(1'b0, "watchdog expired", exp_fetch.size(), 32'h0);
      end
    join_any
    disable fork;
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule